// File: doc/BRIEF.md
# Bank-Group Command Spacing Checker

This block is a passive monitor for a decoded DRAM command stream. Every cycle it looks at one command slot (valid flag, command kind, bank group). It measures how many clock cycles have passed since earlier commands of the kinds that constrain the new one. When a spacing falls below its programmed minimum, it raises a violation. Column commands are checked in three ways: against column commands of the same kind, against earlier writes for write-to-read turnaround, and against earlier reads for read-to-write turnaround. Activates are checked against earlier activates, and also against a rolling window that spans the last four activates.

All minimums arrive as cycle counts on configuration inputs, and they may change between commands. The command slot is observed, never stalled. There is no ready signal and no back-pressure, so a monitor can be attached to any command bus without changing its timing. Spacing between a command in cycle t1 and a command in cycle t2 is t2 − t1. A spacing equal to its minimum is legal.

Top module: `bg_spacing_chk`

## Requirements
- R1: After reset, `viol_pulse`, `viol_code` and `viol_mask` are zero. No check fires until a relevant earlier command has been seen since reset.
- R2: A read following a read, or a write following a write, in the same bank group at spacing below `cfg_ccd_l` sets `viol_mask[0]`.
- R3: The same pairs in different bank groups at spacing below `cfg_ccd_s` set `viol_mask[0]`.
- R4: A read following a write at spacing below `cfg_cwl + cfg_half_bl + cfg_wtr_l` (same bank group) or `cfg_cwl + cfg_half_bl + cfg_wtr_s` (different bank group) sets `viol_mask[1]`.
- R5: A write following a read in any bank group at spacing below `cfg_cl + cfg_half_bl + 1 + cfg_wpre − cfg_cwl` sets `viol_mask[2]`. A negative value of that expression is treated as zero.
- R6: An activate following an activate at spacing below `cfg_rrd_l` (same bank group) or `cfg_rrd_s` (different bank group) sets `viol_mask[3]`.
- R7: An activate that comes fewer than `cfg_faw` cycles after the oldest of the four preceding activates sets `viol_mask[4]`.
- R8: The outputs for a command in cycle t appear in cycle t+1 and last exactly one cycle. `viol_pulse` is high when any mask bit is set. `viol_code` gives the lowest set mask bit as index+1 (1 turnaround-free column, 2 write-to-read, 3 read-to-write, 4 activate pair, 5 window), or 0 when no bit is set.
- R9: A slot with `cmd_valid` low, or with `cmd_type` 0, raises nothing and is not recorded as history. Encoding of `cmd_type`: 1 activate, 2 read, 3 write.
- R10: A spacing exactly equal to its minimum raises no violation.
- R11: Cycle counts saturate instead of wrapping, so a command that follows a gap of more than 1100 cycles raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command slot holds a command |
| cmd_type | input | 2 | 0 other, 1 activate, 2 read, 3 write |
| cmd_bg | input | BG_W | Target bank group |
| cfg_ccd_l | input | CFG_W | Column spacing, same bank group |
| cfg_ccd_s | input | CFG_W | Column spacing, different bank group |
| cfg_rrd_l | input | CFG_W | Activate spacing, same bank group |
| cfg_rrd_s | input | CFG_W | Activate spacing, different bank group |
| cfg_faw | input | CFG_W | Four-activate window length |
| cfg_wtr_l | input | CFG_W | Write-to-read turnaround, same bank group |
| cfg_wtr_s | input | CFG_W | Write-to-read turnaround, different bank group |
| cfg_cl | input | CFG_W | Read latency |
| cfg_cwl | input | CFG_W | Write latency |
| cfg_half_bl | input | CFG_W | Burst length in beats divided by two |
| cfg_wpre | input | CFG_W | Write preamble cycles |
| viol_pulse | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | Highest-priority violated check |
| viol_mask | output | 5 | All checks violated by the last command |

## Verification
The hardest situation to reach is the window check. It needs four activates spread over distinct bank groups, close enough that the pair check stays quiet while the fifth activate still falls inside the window. It also needs a sixth activate, to show that the window slides past the oldest entry. Directed sequences place activates four cycles apart across all bank groups to reach it, then repeat the pattern at exactly the window length. A long random phase with short gaps adds overlapping read, write and activate histories, where several checks fire in one cycle and the priority of the code is tested.

// File: rtl/bgsc_pkg.sv
package bgsc_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER = 2'd0,
    CMD_ACT   = 2'd1,
    CMD_RD    = 2'd2,
    CMD_WR    = 2'd3
  } cmd_e;

  localparam int NUM_CHK = 5;

  typedef enum logic [2:0] {
    VC_NONE = 3'd0,
    VC_CCD  = 3'd1,
    VC_WTR  = 3'd2,
    VC_RTW  = 3'd3,
    VC_RRD  = 3'd4,
    VC_FAW  = 3'd5
  } viol_e;
endpackage

// File: rtl/bgsc_age_ctr.sv
module bgsc_age_ctr #(
  parameter int AGE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic [AGE_W-1:0] age,
  output logic             seen
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  // age equals cycles elapsed since the last load, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= '0;
      seen <= 1'b0;
    end else if (load) begin
      age  <= AGE_W'(1);
      seen <= 1'b1;
    end else if (seen && age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/bgsc_faw_ring.sv
module bgsc_faw_ring #(
  parameter int DEPTH = 4,
  parameter int AGE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  output logic [AGE_W-1:0] oldest_age,
  output logic             oldest_seen
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] ptr;
  logic [AGE_W-1:0] ages  [DEPTH];
  logic [DEPTH-1:0] seens;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    bgsc_age_ctr #(.AGE_W(AGE_W)) u_age (
      .clk  (clk),
      .rst_n(rst_n),
      .load (act && ptr == PTR_W'(e)),
      .age  (ages[e]),
      .seen (seens[e])
    );
  end

  // slot under the pointer is the oldest of the last DEPTH activates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (act) ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  end

  assign oldest_age  = ages[ptr];
  assign oldest_seen = seens[ptr];
endmodule

// File: rtl/bgsc_bg_lane.sv
module bgsc_bg_lane #(
  parameter int AGE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_bg,
  input  logic             is_act,
  input  logic             is_rd,
  input  logic             is_wr,
  input  logic [AGE_W-1:0] ccd_l,
  input  logic [AGE_W-1:0] ccd_s,
  input  logic [AGE_W-1:0] wtr_l,
  input  logic [AGE_W-1:0] wtr_s,
  input  logic [AGE_W-1:0] rtw_min,
  input  logic [AGE_W-1:0] rrd_l,
  input  logic [AGE_W-1:0] rrd_s,
  output logic             ccd_hit,
  output logic             wtr_hit,
  output logic             rtw_hit,
  output logic             rrd_hit
);
  logic [AGE_W-1:0] rd_age, wr_age, act_age;
  logic             rd_seen, wr_seen, act_seen;
  logic [AGE_W-1:0] ccd_sel, wtr_sel, rrd_sel;

  bgsc_age_ctr #(.AGE_W(AGE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .load(is_rd && hit_bg), .age(rd_age), .seen(rd_seen)
  );
  bgsc_age_ctr #(.AGE_W(AGE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(is_wr && hit_bg), .age(wr_age), .seen(wr_seen)
  );
  bgsc_age_ctr #(.AGE_W(AGE_W)) u_act (
    .clk(clk), .rst_n(rst_n), .load(is_act && hit_bg), .age(act_age), .seen(act_seen)
  );

  assign ccd_sel = hit_bg ? ccd_l : ccd_s;
  assign wtr_sel = hit_bg ? wtr_l : wtr_s;
  assign rrd_sel = hit_bg ? rrd_l : rrd_s;

  assign ccd_hit = (is_rd && rd_seen && rd_age < ccd_sel) ||
                   (is_wr && wr_seen && wr_age < ccd_sel);
  assign wtr_hit = is_rd && wr_seen && wr_age < wtr_sel;
  assign rtw_hit = is_wr && rd_seen && rd_age < rtw_min;
  assign rrd_hit = is_act && act_seen && act_age < rrd_sel;
endmodule

// File: rtl/bg_spacing_chk.sv
module bg_spacing_chk
  import bgsc_pkg::*;
#(
  parameter int NUM_BG    = 4,
  parameter int BG_W      = (NUM_BG > 1) ? $clog2(NUM_BG) : 1,
  parameter int CFG_W     = 8,
  parameter int WIN_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_type,
  input  logic [BG_W-1:0]  cmd_bg,
  input  logic [CFG_W-1:0] cfg_ccd_l,
  input  logic [CFG_W-1:0] cfg_ccd_s,
  input  logic [CFG_W-1:0] cfg_rrd_l,
  input  logic [CFG_W-1:0] cfg_rrd_s,
  input  logic [CFG_W-1:0] cfg_faw,
  input  logic [CFG_W-1:0] cfg_wtr_l,
  input  logic [CFG_W-1:0] cfg_wtr_s,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic [CFG_W-1:0] cfg_cwl,
  input  logic [CFG_W-1:0] cfg_half_bl,
  input  logic [CFG_W-1:0] cfg_wpre,
  output logic             viol_pulse,
  output logic [2:0]       viol_code,
  output logic [4:0]       viol_mask
);
  localparam int AGE_W = CFG_W + 2;

  cmd_e kind;
  logic is_act, is_rd, is_wr;
  assign kind   = cmd_e'(cmd_type);
  assign is_act = cmd_valid && kind == CMD_ACT;
  assign is_rd  = cmd_valid && kind == CMD_RD;
  assign is_wr  = cmd_valid && kind == CMD_WR;

  // derived minimums, widened so sums cannot overflow
  logic [AGE_W-1:0] ccd_l, ccd_s, rrd_l, rrd_s, faw;
  logic [AGE_W-1:0] wtr_l, wtr_s, rtw_pos, cwl_x, rtw_min;
  assign ccd_l   = AGE_W'(cfg_ccd_l);
  assign ccd_s   = AGE_W'(cfg_ccd_s);
  assign rrd_l   = AGE_W'(cfg_rrd_l);
  assign rrd_s   = AGE_W'(cfg_rrd_s);
  assign faw     = AGE_W'(cfg_faw);
  assign cwl_x   = AGE_W'(cfg_cwl);
  assign wtr_l   = cwl_x + AGE_W'(cfg_half_bl) + AGE_W'(cfg_wtr_l);
  assign wtr_s   = cwl_x + AGE_W'(cfg_half_bl) + AGE_W'(cfg_wtr_s);
  assign rtw_pos = AGE_W'(cfg_cl) + AGE_W'(cfg_half_bl) + AGE_W'(1) + AGE_W'(cfg_wpre);
  assign rtw_min = (rtw_pos > cwl_x) ? rtw_pos - cwl_x : '0;

  logic [NUM_BG-1:0] ccd_v, wtr_v, rtw_v, rrd_v;

  for (genvar g = 0; g < NUM_BG; g++) begin : g_lane
    bgsc_bg_lane #(.AGE_W(AGE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_bg (cmd_bg == BG_W'(g)),
      .is_act (is_act),
      .is_rd  (is_rd),
      .is_wr  (is_wr),
      .ccd_l  (ccd_l),
      .ccd_s  (ccd_s),
      .wtr_l  (wtr_l),
      .wtr_s  (wtr_s),
      .rtw_min(rtw_min),
      .rrd_l  (rrd_l),
      .rrd_s  (rrd_s),
      .ccd_hit(ccd_v[g]),
      .wtr_hit(wtr_v[g]),
      .rtw_hit(rtw_v[g]),
      .rrd_hit(rrd_v[g])
    );
  end

  logic [AGE_W-1:0] win_age;
  logic             win_full;
  bgsc_faw_ring #(.DEPTH(WIN_DEPTH), .AGE_W(AGE_W)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (is_act),
    .oldest_age (win_age),
    .oldest_seen(win_full)
  );

  logic [NUM_CHK-1:0] mask_d;
  viol_e              code_d;
  assign mask_d = {is_act && win_full && win_age < faw,
                   |rrd_v, |rtw_v, |wtr_v, |ccd_v};

  // lowest set check index wins
  always_comb begin
    code_d = VC_NONE;
    for (int i = NUM_CHK - 1; i >= 0; i--) begin
      if (mask_d[i]) code_d = viol_e'(3'(i + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
      viol_code  <= 3'd0;
      viol_mask  <= '0;
    end else begin
      viol_pulse <= |mask_d;
      viol_code  <= code_d;
      viol_mask  <= mask_d;
    end
  end
endmodule

// File: rtl/bgsc_checker.sv
module bgsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_type,
  input logic       viol_pulse,
  input logic [2:0] viol_code,
  input logic [4:0] viol_mask
);
  a_r8_pulse_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_code != 3'd0);

  a_r8_quiet_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_pulse |-> (viol_code == 3'd0 && viol_mask == 5'd0));

  a_r9_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !viol_pulse);

  a_r9_other_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd0) |=> !viol_pulse);

  a_r7_act_no_col_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd1) |=> viol_mask[2:0] == 3'd0);

  a_r2_col_no_act_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type[1]) |=> viol_mask[4:3] == 2'd0);
endmodule

bind bg_spacing_chk bgsc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_type  (cmd_type),
  .viol_pulse(viol_pulse),
  .viol_code (viol_code),
  .viol_mask (viol_mask)
);

// File: tb/bg_spacing_chk_test.sv
module bg_spacing_chk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic [1:0] cmd_bg = 2'd0;
  logic       viol_pulse;
  logic [2:0] viol_code;
  logic [4:0] viol_mask;

  int m_ccd_l = 6, m_ccd_s = 4, m_rrd_l = 6, m_rrd_s = 4, m_faw = 20;
  int m_wtr_l = 8, m_wtr_s = 3, m_cl = 16, m_cwl = 12, m_hbl = 4, m_wpre = 1;

  always #2 clk = ~clk;

  bg_spacing_chk uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bg(cmd_bg),
    .cfg_ccd_l(8'(m_ccd_l)), .cfg_ccd_s(8'(m_ccd_s)), .cfg_rrd_l(8'(m_rrd_l)),
    .cfg_rrd_s(8'(m_rrd_s)), .cfg_faw(8'(m_faw)), .cfg_wtr_l(8'(m_wtr_l)),
    .cfg_wtr_s(8'(m_wtr_s)), .cfg_cl(8'(m_cl)), .cfg_cwl(8'(m_cwl)),
    .cfg_half_bl(8'(m_hbl)), .cfg_wpre(8'(m_wpre)),
    .viol_pulse(viol_pulse), .viol_code(viol_code), .viol_mask(viol_mask)
  );

  typedef struct { int t; int ty; int bg; } ev_t;
  ev_t   hist[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  logic [4:0] exp_mask = 5'd0;
  string cur_req = "R1";

  function automatic logic [4:0] model(int ty, int bg, int t);
    logic [4:0] m = 5'd0;
    int rtw = m_cl - m_cwl + m_hbl + 1 + m_wpre;
    int acts = 0;
    if (rtw < 0) rtw = 0;
    foreach (hist[i]) begin
      int  d = t - hist[i].t;
      bit  same = (hist[i].bg == bg);
      if (ty == 2 && hist[i].ty == 2 && d < (same ? m_ccd_l : m_ccd_s)) m[0] = 1'b1;
      if (ty == 3 && hist[i].ty == 3 && d < (same ? m_ccd_l : m_ccd_s)) m[0] = 1'b1;
      if (ty == 2 && hist[i].ty == 3 && d < m_cwl + m_hbl + (same ? m_wtr_l : m_wtr_s)) m[1] = 1'b1;
      if (ty == 3 && hist[i].ty == 2 && d < rtw) m[2] = 1'b1;
      if (ty == 1 && hist[i].ty == 1 && d < (same ? m_rrd_l : m_rrd_s)) m[3] = 1'b1;
    end
    if (ty == 1) begin
      for (int i = hist.size() - 1; i >= 0; i--) begin
        if (hist[i].ty == 1) begin
          acts++;
          if (acts == 4 && t - hist[i].t < m_faw) m[4] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  task automatic compare();
    int ecode = 0;
    for (int i = 4; i >= 0; i--) if (exp_mask[i]) ecode = i + 1;
    checks++;
    if (viol_mask !== exp_mask || viol_code !== 3'(ecode) || viol_pulse !== (|exp_mask)) begin
      failures++;
      $display("FAIL %s cyc=%0d actual mask=%b code=%0d pulse=%b expected mask=%b code=%0d pulse=%b",
               cur_req, cyc, viol_mask, viol_code, viol_pulse, exp_mask, ecode, |exp_mask);
    end
  endtask

  task automatic step(bit v, int ty, int bg);
    @(negedge clk);
    compare();
    cyc++;
    cmd_valid = v;
    cmd_type  = 2'(ty);
    cmd_bg    = 2'(bg);
    if (v && ty != 0) begin
      exp_mask = model(ty, bg, cyc);
      hist.push_back('{t: cyc, ty: ty, bg: bg});
      if (hist.size() > 512) void'(hist.pop_front());
    end else begin
      exp_mask = 5'd0;
    end
  endtask

  task automatic issue(int ty, int bg, int gap);
    step(1'b1, ty, bg);
    for (int i = 1; i < gap; i++) step(1'b0, 0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs clear while in reset
    checks++;
    if (viol_pulse !== 1'b0 || viol_code !== 3'd0 || viol_mask !== 5'd0) begin
      failures++;
      $display("FAIL R1 reset actual pulse=%b code=%0d mask=%b expected 0 0 0",
               viol_pulse, viol_code, viol_mask);
    end
    rst_n = 1'b1;
    // R1: first commands of every kind raise nothing
    cur_req = "R1"; issue(2, 0, 1); issue(1, 1, 1); issue(3, 2, 1); idle(40);
    // R2 and R10: same-group column spacing
    cur_req = "R2"; issue(2, 0, 5); issue(2, 0, 6); issue(2, 0, 30);
    issue(3, 1, 5); issue(3, 1, 6); issue(3, 1, 40);
    cur_req = "R10"; issue(2, 3, 6); issue(2, 3, 40);
    // R3: cross-group column spacing
    cur_req = "R3"; issue(2, 0, 3); issue(2, 1, 4); issue(2, 2, 40);
    issue(3, 0, 3); issue(3, 3, 40);
    // R4: write-to-read turnaround
    cur_req = "R4"; issue(3, 0, 23); issue(2, 0, 40); issue(3, 0, 24); issue(2, 0, 40);
    issue(3, 0, 18); issue(2, 1, 40); issue(3, 0, 19); issue(2, 1, 40);
    // R5: read-to-write turnaround
    cur_req = "R5"; issue(2, 0, 9); issue(3, 2, 40); issue(2, 0, 10); issue(3, 2, 40);
    m_cl = 5; issue(2, 0, 1); issue(3, 3, 40); m_cl = 16;
    // R8: two checks at once, priority of the code
    cur_req = "R8"; issue(2, 0, 2); issue(3, 1, 2); issue(2, 0, 40);
    // R6: activate pairs
    cur_req = "R6"; issue(1, 0, 5); issue(1, 0, 6); issue(1, 0, 3); issue(1, 1, 4);
    issue(1, 2, 40);
    // R7: rolling four-activate window, then exactly at the window
    cur_req = "R7"; issue(1, 0, 4); issue(1, 1, 4); issue(1, 2, 4); issue(1, 3, 4);
    issue(1, 0, 4); issue(1, 1, 40);
    issue(1, 0, 5); issue(1, 1, 5); issue(1, 2, 5); issue(1, 3, 5); issue(1, 0, 40);
    // R9: invalid and other-kind slots are not history
    cur_req = "R9"; issue(2, 0, 2); step(1'b0, 2, 0); step(1'b1, 0, 0); step(1'b0, 3, 0);
    step(1'b0, 2, 0); issue(2, 0, 40);
    // R11: long gap saturates
    cur_req = "R11"; issue(3, 0, 1); idle(1100); issue(2, 0, 6); issue(3, 0, 40);
    // mixed random traffic against the model
    cur_req = "R8";
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 9) < 4) step(1'b1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      else step(1'b0, int'($urandom_range(0, 3)), 0);
    end
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule